// File: doc/BRIEF.md
# Receive Character Buffer with Hardware Flow Control

This block sits between a serial receiver and the CPU. The receive shift register delivers each completed character as a one-cycle write strobe with a byte. The block holds these bytes in a 16-entry first-in first-out store, and the CPU takes them out with a read strobe. The oldest byte is always visible on the read data port, and a flag tells the CPU when data is there. A sticky error flag records every character that arrived while the store was full, and the CPU clears it with a strobe.

The block also drives a request-to-send line toward the far-end transmitter. High means the transmitter may send and low means it should pause. A 2-bit code sets how many free entries must still remain when the line drops. The CPU picks a larger margin when the transmitter keeps sending a few characters after it is told to stop. Characters that arrive after the line drops are still stored while space remains. The line rises again only after the CPU has freed two entries more than the drop margin, so a single read or write near the limit cannot make it toggle.

Top module: `rxq_fifo_rts`

## Requirements
- R1: Bytes leave in the order they were written. While `data_avail` is 1, `rd_data` shows the oldest stored byte. While the store is empty, `rd_data` is 0.
- R2: `level` counts the stored bytes, from 0 to 16, and `data_avail` is 1 exactly when `level` is not 0. All outputs update at the clock edge that samples the strobe.
- R3: While `flow_en` is 0, `rts` is 1 from the next edge on.
- R4: `thr_sel` codes 00, 01, 10 and 11 select a margin of 0, 2, 4 and 8 free entries. With flow control enabled and `rts` at 1, `rts` drops to 0 at the edge where the free count (16 minus `level`) becomes less than or equal to the margin.
- R5: While `rts` is 0, writes are still stored until `level` reaches 16, and no error is raised.
- R6: Once `rts` is 0, it returns to 1 at the edge where the free count reaches the margin plus 2. While the free count equals the margin plus 1, `rts` stays 0.
- R7: A write while `level` is 16 drops the byte and leaves the stored bytes and `level` untouched. A read in the same cycle still removes the oldest byte. The write also sets `overrun`, which stays 1 until an `ovr_clr` cycle. When a new error and `ovr_clr` arrive in the same cycle, the flag stays set.
- R8: A read and a write in the same cycle with `level` between 1 and 15 leave `level` unchanged. A read while empty is ignored. A write together with a read while empty stores the byte.
- R9: During and after reset, `level` is 0, `data_avail` is 0, `overrun` is 0, `rts` is 1 and `rd_data` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | One-cycle strobe: a received byte is ready |
| wr_data | input | 8 | Received byte |
| rd_en | input | 1 | One-cycle strobe: pop the oldest byte |
| flow_en | input | 1 | Enables hardware flow control on `rts` |
| thr_sel | input | 2 | Drop margin code (00/01/10/11 = 0/2/4/8 free entries) |
| ovr_clr | input | 1 | Clears the sticky overrun flag |
| rd_data | output | 8 | Oldest stored byte, 0 when empty |
| data_avail | output | 1 | At least one byte is stored |
| overrun | output | 1 | Sticky: a byte was lost because the store was full |
| level | output | 5 | Number of stored bytes |
| rts | output | 1 | 1 = far end may send, 0 = far end should pause |

## Verification
The checker watches on every cycle that `level` stays in range, that `rts` falls and rises only at the free counts that R4 and R6 allow, and that `rts` is held high while flow control is off. It also checks that `overrun` rises only on a write into a full store and stays set until cleared, and that a combined read and write, or a read from an empty store, leaves the count as it was. Byte ordering, the hold point one entry inside the hysteresis, the dropped byte on overrun and the set-wins-over-clear case are shown only by the bench's scenarios against its queue model.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

    localparam int RXQ_DW    = 8;
    localparam int RXQ_DEPTH = 16;

    typedef enum logic {
        RTS_PAUSE = 1'b0,
        RTS_SEND  = 1'b1
    } rts_state_e;

    // Per-cycle decision taken by the store from the two strobes
    typedef struct packed {
        logic push;
        logic pop;
        logic drop;
    } rxq_op_t;

    // Free entries at which the request line drops: 0, 2, 4 or 8
    function automatic int stop_slots(input logic [1:0] sel);
        return (sel == 2'b00) ? 0 : (1 << sel);
    endfunction

endpackage

// File: rtl/rxq_store.sv
module rxq_store
    import rxq_pkg::*;
#(
    parameter int DW    = RXQ_DW,
    parameter int DEPTH = RXQ_DEPTH
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         wr_en,
    input  logic [DW-1:0]                wr_data,
    input  logic                         rd_en,
    output logic [DW-1:0]                rd_data,
    output logic [$clog2(DEPTH+1)-1:0]   level,
    output logic [$clog2(DEPTH+1)-1:0]   level_nxt,
    output logic                         drop
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
    localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);

    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    rxq_op_t       op;

    function automatic logic [AW-1:0] ptr_step(input logic [AW-1:0] p);
        return (p == LAST_IDX) ? '0 : p + AW'(1);
    endfunction

    always_comb begin
        op.pop    = rd_en && (level != '0);
        op.push   = wr_en && (level != FULL_CNT);
        op.drop   = wr_en && (level == FULL_CNT);
        level_nxt = level + CW'(op.push) - CW'(op.pop);
    end

    assign drop    = op.drop;
    assign rd_data = (level != '0) ? mem[rd_ptr] : '0;

    always_ff @(posedge clk) begin
        if (op.push) begin
            mem[wr_ptr] <= wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            level  <= '0;
        end else begin
            if (op.push) wr_ptr <= ptr_step(wr_ptr);
            if (op.pop)  rd_ptr <= ptr_step(rd_ptr);
            level <= level_nxt;
        end
    end

endmodule

// File: rtl/rxq_flow.sv
module rxq_flow
    import rxq_pkg::*;
#(
    parameter int DEPTH = RXQ_DEPTH
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         flow_en,
    input  logic [1:0]                   thr_sel,
    input  logic [$clog2(DEPTH+1)-1:0]   level_nxt,
    output logic                         rts
);
    rts_state_e state_q, state_d;
    int         free_nxt;
    int         margin;

    // Decide on the count that will hold after this edge, so the line
    // moves in the same cycle as the level output.
    always_comb begin
        free_nxt = DEPTH - int'(level_nxt);
        margin   = stop_slots(thr_sel);
        state_d  = state_q;
        if (!flow_en) begin
            state_d = RTS_SEND;
        end else if (state_q == RTS_SEND) begin
            if (free_nxt <= margin) state_d = RTS_PAUSE;
        end else begin
            if (free_nxt >= margin + 2) state_d = RTS_SEND;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= RTS_SEND;
        else     state_q <= state_d;
    end

    assign rts = (state_q == RTS_SEND);

endmodule

// File: rtl/rxq_ovr.sv
module rxq_ovr (
    input  logic clk,
    input  logic rst,
    input  logic drop,
    input  logic clr,
    output logic flag
);
    always_ff @(posedge clk) begin
        if (rst)       flag <= 1'b0;
        else if (drop) flag <= 1'b1;
        else if (clr)  flag <= 1'b0;
    end
endmodule

// File: rtl/rxq_fifo_rts.sv
module rxq_fifo_rts
    import rxq_pkg::*;
#(
    parameter int DW    = RXQ_DW,
    parameter int DEPTH = RXQ_DEPTH
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         wr_en,
    input  logic [DW-1:0]                wr_data,
    input  logic                         rd_en,
    input  logic                         flow_en,
    input  logic [1:0]                   thr_sel,
    input  logic                         ovr_clr,
    output logic [DW-1:0]                rd_data,
    output logic                         data_avail,
    output logic                         overrun,
    output logic [$clog2(DEPTH+1)-1:0]   level,
    output logic                         rts
);
    localparam int CW = $clog2(DEPTH + 1);

    logic [CW-1:0] level_nxt;
    logic          drop;

    rxq_store #(.DW(DW), .DEPTH(DEPTH)) u_store (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .rd_en     (rd_en),
        .rd_data   (rd_data),
        .level     (level),
        .level_nxt (level_nxt),
        .drop      (drop)
    );

    rxq_flow #(.DEPTH(DEPTH)) u_flow (
        .clk       (clk),
        .rst       (rst),
        .flow_en   (flow_en),
        .thr_sel   (thr_sel),
        .level_nxt (level_nxt),
        .rts       (rts)
    );

    rxq_ovr u_ovr (
        .clk  (clk),
        .rst  (rst),
        .drop (drop),
        .clr  (ovr_clr),
        .flag (overrun)
    );

    assign data_avail = (level != '0);

endmodule

// File: rtl/rxq_fifo_rts_chk.sv
module rxq_fifo_rts_chk
    import rxq_pkg::*;
#(
    parameter int DW    = RXQ_DW,
    parameter int DEPTH = RXQ_DEPTH
) (
    input logic                         clk,
    input logic                         rst,
    input logic                         wr_en,
    input logic                         rd_en,
    input logic                         flow_en,
    input logic [1:0]                   thr_sel,
    input logic                         ovr_clr,
    input logic                         overrun,
    input logic [$clog2(DEPTH+1)-1:0]   level,
    input logic                         rts
);
    // R2
    level_bound_chk: assert property (@(posedge clk) disable iff (rst)
        int'(level) <= DEPTH);

    // R3
    rts_off_chk: assert property (@(posedge clk) disable iff (rst)
        !flow_en |=> rts);

    // R4
    rts_fall_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(rts) |-> ($past(flow_en) &&
                        (DEPTH - int'(level)) <= stop_slots($past(thr_sel))));

    // R6
    rts_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(rts) |-> (!$past(flow_en) ||
                        (DEPTH - int'(level)) >= stop_slots($past(thr_sel)) + 2));

    // R7
    ovr_set_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(overrun) |-> ($past(wr_en) && int'($past(level)) == DEPTH));

    // R7
    ovr_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (overrun && !ovr_clr) |=> overrun);

    // R8
    rw_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && rd_en && level != '0 && int'(level) != DEPTH) |=> $stable(level));

    // R8
    empty_rd_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_en && !wr_en && level == '0) |=> (level == '0));

endmodule

bind rxq_fifo_rts rxq_fifo_rts_chk #(.DW(DW), .DEPTH(DEPTH)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .rd_en   (rd_en),
    .flow_en (flow_en),
    .thr_sel (thr_sel),
    .ovr_clr (ovr_clr),
    .overrun (overrun),
    .level   (level),
    .rts     (rts)
);

// File: tb/rxq_fifo_rts_tb.sv
module rxq_fifo_rts_tb;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 16;

    logic       clk = 1'b0;
    logic       rst;
    logic       wr_en, rd_en, flow_en, ovr_clr;
    logic [7:0] wr_data;
    logic [1:0] thr_sel;
    logic [7:0] rd_data;
    logic       data_avail, overrun, rts;
    logic [4:0] level;

    int  n_chk = 0;
    int  n_bad = 0;
    bit  done  = 0;

    // behavioural model
    byte unsigned mq[$];
    bit           m_ovr = 0;
    bit           m_rts = 1;

    rxq_fifo_rts u_dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
        .flow_en(flow_en), .thr_sel(thr_sel), .ovr_clr(ovr_clr),
        .rd_data(rd_data), .data_avail(data_avail), .overrun(overrun),
        .level(level), .rts(rts)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic int margin_of(input logic [1:0] s);
        case (s)
            2'b00:   return 0;
            2'b01:   return 2;
            2'b10:   return 4;
            default: return 8;
        endcase
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            mq.delete();
            m_ovr = 0;
            m_rts = 1;
        end else begin
            bit full;
            int fr;
            full = (mq.size() == DEPTH);
            if (rd_en && mq.size() > 0) void'(mq.pop_front());
            if (wr_en && !full) mq.push_back(wr_data);
            if (wr_en && full) m_ovr = 1;
            else if (ovr_clr)  m_ovr = 0;
            fr = DEPTH - mq.size();
            if (!flow_en)                               m_rts = 1;
            else if (m_rts && fr <= margin_of(thr_sel)) m_rts = 0;
            else if (!m_rts && fr >= margin_of(thr_sel) + 2) m_rts = 1;
        end
    end

    task automatic check(input string tag, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // every-cycle comparison with the model
    always @(negedge clk) begin
        if (!rst && !done) begin
            check("R2", "level", int'(level), mq.size());
            check("R2", "data_avail", int'(data_avail), int'(mq.size() != 0));
            check("R1", "rd_data", int'(rd_data), (mq.size() != 0) ? int'(mq[0]) : 0);
            check("R7", "overrun", int'(overrun), int'(m_ovr));
            check(flow_en ? "R4" : "R3", "rts", int'(rts), int'(m_rts));
        end
    end

    task automatic cyc(input bit w, input byte unsigned d, input bit r);
        wr_en   = w;
        wr_data = d;
        rd_en   = r;
        @(negedge clk);
    endtask

    task automatic drain();
        while (mq.size() > 0) cyc(0, 0, 1);
        cyc(0, 0, 0);
    endtask

    task automatic summary();
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        rst = 1; wr_en = 0; rd_en = 0; wr_data = 0;
        flow_en = 0; thr_sel = 0; ovr_clr = 0;
        repeat (3) @(negedge clk);
        // R9 reset state
        check("R9", "level", int'(level), 0);
        check("R9", "data_avail", int'(data_avail), 0);
        check("R9", "overrun", int'(overrun), 0);
        check("R9", "rts", int'(rts), 1);
        check("R9", "rd_data", int'(rd_data), 0);
        rst = 0;

        // margin 0: drop only when full, then overrun and ordered drain
        flow_en = 1; thr_sel = 2'b00;
        for (int i = 0; i < 15; i++) cyc(1, byte'(i + 1), 0);
        check("R4", "rts at one free", int'(rts), 1);
        cyc(1, 16, 0);
        check("R4", "rts at full", int'(rts), 0);
        check("R5", "level full", int'(level), 16);
        cyc(1, 8'hEE, 0);
        check("R7", "overrun set", int'(overrun), 1);
        check("R7", "level after drop", int'(level), 16);
        cyc(0, 0, 0);
        check("R7", "overrun sticky", int'(overrun), 1);
        for (int i = 0; i < 16; i++) begin
            check("R1", "order", int'(rd_data), i + 1);
            cyc(0, 0, 1);
            if (i == 0) check("R6", "hold at margin+1", int'(rts), 0);
            if (i == 1) check("R6", "reassert at margin+2", int'(rts), 1);
        end
        ovr_clr = 1; cyc(0, 0, 0); ovr_clr = 0;
        check("R7", "overrun cleared", int'(overrun), 0);

        // margin 2
        thr_sel = 2'b01;
        for (int i = 0; i < 13; i++) cyc(1, byte'(8'h20 + i), 0);
        check("R4", "rts free 3", int'(rts), 1);
        cyc(1, 8'h2D, 0);
        check("R4", "rts free 2", int'(rts), 0);
        cyc(1, 8'h2E, 0); cyc(1, 8'h2F, 0);
        check("R5", "late chars stored", int'(level), 16);
        check("R5", "no overrun", int'(overrun), 0);
        cyc(0, 0, 1); cyc(0, 0, 1); cyc(0, 0, 1);
        check("R6", "hold free 3", int'(rts), 0);
        cyc(0, 0, 1);
        check("R6", "reassert free 4", int'(rts), 1);
        drain();

        // margin 8
        thr_sel = 2'b11;
        for (int i = 0; i < 7; i++) cyc(1, byte'(8'h40 + i), 0);
        check("R4", "rts free 9", int'(rts), 1);
        cyc(1, 8'h47, 0);
        check("R4", "rts free 8", int'(rts), 0);
        for (int i = 0; i < 8; i++) cyc(1, byte'(8'h48 + i), 0);
        check("R5", "filled to 16", int'(level), 16);
        for (int i = 0; i < 9; i++) cyc(0, 0, 1);
        check("R6", "hold level 7", int'(rts), 0);
        cyc(0, 0, 1);
        check("R6", "reassert level 6", int'(rts), 1);
        drain();

        // R8 simultaneous and empty reads
        cyc(1, 8'hA1, 0); cyc(1, 8'hA2, 0);
        cyc(1, 8'hA3, 1);
        check("R8", "level rd+wr", int'(level), 2);
        check("R8", "head after rd+wr", int'(rd_data), 8'hA2);
        drain();
        cyc(0, 0, 1);
        check("R8", "empty read level", int'(level), 0);
        check("R8", "empty read avail", int'(data_avail), 0);
        cyc(1, 8'h55, 1);
        check("R8", "wr+rd on empty", int'(level), 1);
        check("R8", "wr+rd on empty data", int'(rd_data), 8'h55);
        drain();

        // R3 flow off: fills without dropping rts
        flow_en = 0;
        for (int i = 0; i < 16; i++) cyc(1, byte'(i), 0);
        check("R3", "rts with flow off", int'(rts), 1);
        // full with read and write together
        cyc(1, 8'h99, 1);
        check("R7", "full rd+wr level", int'(level), 15);
        check("R7", "full rd+wr overrun", int'(overrun), 1);
        cyc(1, 8'h77, 0);
        ovr_clr = 1; cyc(1, 8'h78, 0); ovr_clr = 0;
        check("R7", "set wins over clear", int'(overrun), 1);
        ovr_clr = 1; cyc(0, 0, 0); ovr_clr = 0;
        check("R7", "cleared", int'(overrun), 0);
        drain();

        // random traffic against the model
        for (int i = 0; i < 5000; i++) begin
            if (($urandom % 64) == 0) thr_sel = 2'($urandom);
            if (($urandom % 128) == 0) flow_en = ~flow_en;
            ovr_clr = (($urandom % 32) == 0);
            cyc(($urandom % 3) != 0, 8'($urandom), ($urandom % 2) == 0);
        end
        ovr_clr = 0;
        cyc(0, 0, 0);
        summary();
    end
endmodule